// File: doc/BRIEF.md
# Filler Instruction Insertion Gate

This block sits in the fetch stage of an in-order pipelined core. It decides when a filler instruction may take the place of a real fetched instruction on the fetch-to-decode handoff. A random insertion request arrives from outside. The gate accepts it only when the core state permits. Once a filler is selected it stays selected until decode accepts it or a fetch kill flushes it. While a filler is selected, the gate stops the prefetch buffer from popping and freezes the fetch program counter.

Forward progress is counted in accepted transfers, not in clock cycles. A one-bit tracker records whether the last completed transfer carried a filler. While it is set, the gate refuses a new filler, however many stall cycles pass before the next transfer. A fetch kill clears both the tracker and any pending filler, so a filler is allowed again right after a flush.

Top module: `filler_gate`

## Requirements
- R1: `fill_sel_o` stays 0 while no filler is pending if any of these holds: `step_mode_i` is 1, `dbg_mode_i` is 1, `pf_valid_i` is 0, or `first_op_i` is 0.
- R2: `fill_sel_o` stays 0 while no filler is pending and `seq_busy_i` is 1, meaning the sequencer is partway through a multi-operation instruction.
- R3: `pop_block_o` is 1 exactly when `fill_sel_o` is 1, `pf_valid_i` is 1 and `fetch_kill_i` is 0.
- R4: In a cycle where `fill_sel_o` is 1 and `fetch_kill_i` is 0, `pc_o` keeps its value on the next cycle.
- R5: After a filler is accepted (`fetch_valid_i` and `dec_ready_i` both 1, no kill), the next accepted transfer carries a real instruction (`fill_sel_o` is 0), whatever the number of stall cycles in between.
- R6: A selected filler that is not accepted and not killed stays selected on the next cycle, even if the request and the permit conditions drop.
- R7: `fetch_kill_i` cancels a pending filler and clears the progress tracker. On the next cycle `pc_o` takes the value of `pc_next_i`.
- R8: The gate drops a request that arrives while insertion is not permitted. It does not store the request, and no filler follows once the block lifts unless a new request is present.
- R9: After reset, `pc_o` equals the parameter `RESET_PC` (default 0x0000_0080), no filler is pending, and the tracker is clear.
- R10: An accepted real-instruction transfer without a kill loads `pc_next_i` into `pc_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_req_i | input | 1 | Random filler insertion request |
| step_mode_i | input | 1 | Single-step mode active |
| dbg_mode_i | input | 1 | Core is in debug mode |
| pf_valid_i | input | 1 | Prefetched data valid |
| first_op_i | input | 1 | Fetch holds the first operation of a non-filler instruction |
| seq_busy_i | input | 1 | Multi-operation sequencer is mid-sequence |
| fetch_valid_i | input | 1 | Fetch stage output valid |
| dec_ready_i | input | 1 | Decode stage ready |
| fetch_kill_i | input | 1 | Fetch stage flush |
| pc_next_i | input | PC_W | Next fetch PC, or the redirect target when killed |
| fill_sel_o | output | 1 | Filler replaces the fetched instruction this cycle |
| pop_block_o | output | 1 | Suppress the prefetch buffer pop |
| pc_o | output | PC_W | Held fetch program counter |

## Verification
The hardest case for R5 is a filler that is accepted and then followed by a long stall. During that stall every permit input is true and the request is held high, so a gate that counted cycles instead of transfers would let a second filler through. The stimulus builds this case on purpose: it accepts a filler and then holds `dec_ready_i` low for several cycles with the request asserted. After that, a long random phase drives sparse ready/valid, frequent requests and rare kills. A scoreboard follows the order of accepted transfers and reports any two fillers in a row.

// File: rtl/filler_pkg.sv
package filler_pkg;
  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_REAL = 2'd1,
    XFER_FILL = 2'd2
  } xfer_kind_e;
endpackage

// File: rtl/filler_permit.sv
module filler_permit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic step_i,
  input  logic dbg_i,
  input  logic pf_valid_i,
  input  logic first_op_i,
  input  logic seq_busy_i,
  input  logic last_fill_i,
  input  logic xfer_i,
  input  logic kill_i,
  output logic fill_sel_o,
  output logic pend_o
);
  logic allow_w;
  logic pend_q;

  // Any core state that blocks insertion turns the request off here; a blocked request is not stored
  assign allow_w = !step_i && !dbg_i && pf_valid_i && first_op_i
                   && !seq_busy_i && !last_fill_i;

  assign fill_sel_o = pend_q || (allow_w && req_i);
  assign pend_o     = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (kill_i) pend_q <= 1'b0;
    else             pend_q <= fill_sel_o && !xfer_i;
  end

  a_r1_blocked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i || dbg_i || !pf_valid_i || !first_op_i) && !pend_q |-> !fill_sel_o);

  a_r2_mid_sequence : assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy_i && !pend_q |-> !fill_sel_o);

  a_r6_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_sel_o && !xfer_i && !kill_i |=> fill_sel_o);

  a_r7_kill_cancels : assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !pend_q);
endmodule

// File: rtl/filler_progress.sv
module filler_progress
  import filler_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_sel_i,
  input  logic xfer_i,
  input  logic kill_i,
  output logic last_fill_o
);
  xfer_kind_e kind_w;
  logic       last_fill_q;

  always_comb begin
    kind_w = XFER_NONE;
    if (xfer_i) kind_w = fill_sel_i ? XFER_FILL : XFER_REAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_fill_q <= 1'b0;
    else if (kill_i)  last_fill_q <= 1'b0;
    else begin
      unique case (kind_w)
        XFER_FILL: last_fill_q <= 1'b1;
        XFER_REAL: last_fill_q <= 1'b0;
        default:   last_fill_q <= last_fill_q;
      endcase
    end
  end

  assign last_fill_o = last_fill_q;

  a_r5_no_back_to_back : assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_fill_q && xfer_i && !kill_i |-> !fill_sel_i);
endmodule

// File: rtl/filler_pc_hold.sv
module filler_pc_hold #(
  parameter int unsigned          PC_W     = 32,
  parameter logic [PC_W-1:0]      RESET_PC = 32'h0000_0080
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fill_sel_i,
  input  logic            xfer_i,
  input  logic            kill_i,
  input  logic [PC_W-1:0] pc_next_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;
  logic            load_w;

  // Kill always wins; a filler never advances the PC
  assign load_w = kill_i || (xfer_i && !fill_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= RESET_PC;
    else if (load_w) pc_q <= pc_next_i;
  end

  assign pc_o = pc_q;

  a_r4_pc_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_sel_i && !kill_i |=> pc_q == $past(pc_q));

  a_r7_kill_loads : assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> pc_q == $past(pc_next_i));
endmodule

// File: rtl/filler_gate.sv
module filler_gate #(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0080
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fill_req_i,
  input  logic            step_mode_i,
  input  logic            dbg_mode_i,
  input  logic            pf_valid_i,
  input  logic            first_op_i,
  input  logic            seq_busy_i,
  input  logic            fetch_valid_i,
  input  logic            dec_ready_i,
  input  logic            fetch_kill_i,
  input  logic [PC_W-1:0] pc_next_i,
  output logic            fill_sel_o,
  output logic            pop_block_o,
  output logic [PC_W-1:0] pc_o
);
  logic xfer_w;
  logic fill_sel_w;
  logic last_fill_w;
  logic pend_w;

  assign xfer_w = fetch_valid_i && dec_ready_i;

  filler_permit u_permit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (fill_req_i),
    .step_i      (step_mode_i),
    .dbg_i       (dbg_mode_i),
    .pf_valid_i  (pf_valid_i),
    .first_op_i  (first_op_i),
    .seq_busy_i  (seq_busy_i),
    .last_fill_i (last_fill_w),
    .xfer_i      (xfer_w),
    .kill_i      (fetch_kill_i),
    .fill_sel_o  (fill_sel_w),
    .pend_o      (pend_w)
  );

  filler_progress u_progress (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_sel_i  (fill_sel_w),
    .xfer_i      (xfer_w),
    .kill_i      (fetch_kill_i),
    .last_fill_o (last_fill_w)
  );

  filler_pc_hold #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_sel_i (fill_sel_w),
    .xfer_i     (xfer_w),
    .kill_i     (fetch_kill_i),
    .pc_next_i  (pc_next_i),
    .pc_o       (pc_o)
  );

  assign fill_sel_o  = fill_sel_w;
  assign pop_block_o = fill_sel_w && pf_valid_i && !fetch_kill_i;

  a_r3_pop_follows_sel : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_block_o |-> pend_w || fill_req_i);

  a_r9_reset_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pend_w && !last_fill_w);
endmodule

// File: tb/filler_gate_bench.sv
module filler_gate_bench;
  localparam int unsigned PC_W     = 32;
  localparam logic [31:0] RESET_PC = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req, step, dbg, pf, first, busy, fv, dr, kill;
  logic [PC_W-1:0] nxt;
  logic sel_o, pop_o;
  logic [PC_W-1:0] pc_o;

  always #10 clk = ~clk;

  filler_gate #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_filler_gate (
    .clk_i(clk), .rst_ni(rst_n), .fill_req_i(req), .step_mode_i(step),
    .dbg_mode_i(dbg), .pf_valid_i(pf), .first_op_i(first), .seq_busy_i(busy),
    .fetch_valid_i(fv), .dec_ready_i(dr), .fetch_kill_i(kill),
    .pc_next_i(nxt), .fill_sel_o(sel_o), .pop_block_o(pop_o), .pc_o(pc_o)
  );

  typedef struct {
    string           tag;
    logic            sel;
    logic            pop;
    logic [PC_W-1:0] pc;
    logic            xfer;
    logic            kill;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic sb_prev_fill = 1'b0;

  // model state built from the requirements
  logic            m_pend = 1'b0;
  logic            m_last = 1'b0;
  logic [PC_W-1:0] m_pc   = RESET_PC;

  task automatic chk(input string tag, input string what, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic r, st, dg, p, f, b, v, d, k,
                     input logic [PC_W-1:0] n);
    logic allow, sel, xf;
    item_t it;
    @(negedge clk);
    req = r; step = st; dbg = dg; pf = p; first = f; busy = b;
    fv = v; dr = d; kill = k; nxt = n;
    allow = !st && !dg && p && f && !b && !m_last;
    sel   = m_pend || (allow && r);
    xf    = v && d;
    it.tag = tag; it.sel = sel; it.pop = sel && p && !k; it.pc = m_pc;
    it.xfer = xf; it.kill = k;
    q.push_back(it);
    @(posedge clk);
    if (k) begin
      m_pend = 1'b0; m_last = 1'b0; m_pc = n;
    end else begin
      m_pend = sel && !xf;
      if (xf) m_last = sel;
      if (xf && !sel) m_pc = n;
    end
  endtask

  // monitor: compares combinational outputs mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "fill_sel", {31'b0, sel_o}, {31'b0, it.sel});
        chk("R3", "pop_block", {31'b0, pop_o}, {31'b0, it.pop});
        chk("R4/R10", "pc", pc_o, it.pc);
        if (it.kill) sb_prev_fill = 1'b0;
        else if (it.xfer) begin
          if (sb_prev_fill && sel_o) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 back-to-back filler actual=1 expected=0 at %0t", $time);
          end else n_cmp++;
          sb_prev_fill = sel_o;
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    req = 0; step = 0; dbg = 0; pf = 0; first = 0; busy = 0;
    fv = 0; dr = 0; kill = 0; nxt = '0;
    #25;
    // R9: reset state
    chk("R9", "pc reset", pc_o, RESET_PC);
    chk("R9", "sel reset", {31'b0, sel_o}, 32'd0);
    rst_n = 1'b1;

    // R1: each blocking condition
    cyc("R1", 1,1,0,1,1,0,0,0,0, 32'h100);
    cyc("R1", 1,0,1,1,1,0,0,0,0, 32'h100);
    cyc("R1", 1,0,0,0,1,0,0,0,0, 32'h100);
    cyc("R1", 1,0,0,1,0,0,0,0,0, 32'h100);
    // R2: sequencer busy
    cyc("R2", 1,0,0,1,1,1,1,1,0, 32'h104);
    // R8: masked request dropped
    cyc("R8", 1,0,0,1,1,1,0,0,0, 32'h108);
    cyc("R8", 0,0,0,1,1,0,0,0,0, 32'h108);
    // R6: filler pending while decode stalls, request and permit drop
    cyc("R6", 1,0,0,1,1,0,1,0,0, 32'h10c);
    cyc("R6", 0,0,0,0,0,1,1,0,0, 32'h10c);
    cyc("R6", 0,1,0,1,1,0,1,0,0, 32'h10c);
    // accept filler
    cyc("R6", 0,0,0,1,1,0,1,1,0, 32'h10c);
    // R5: long stall with permit true, request high
    for (int i = 0; i < 6; i++) cyc("R5", 1,0,0,1,1,0,1,0,0, 32'h10c);
    cyc("R5", 1,0,0,1,1,0,1,1,0, 32'h10c);
    // R10: real transfer advanced pc; next filler allowed
    cyc("R10", 1,0,0,1,1,0,0,0,0, 32'h110);
    // R7: kill during pending filler
    cyc("R7", 1,0,0,1,1,0,1,0,1, 32'h200);
    cyc("R7", 0,0,0,1,1,0,0,0,0, 32'h204);
    // R7: kill clears tracker, filler allowed right after
    cyc("R7", 1,0,0,1,1,0,1,1,0, 32'h204);
    cyc("R7", 0,0,0,1,1,0,0,0,1, 32'h300);
    cyc("R7", 1,0,0,1,1,0,1,1,0, 32'h304);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] rnd;
      rnd = 8'($urandom);
      cyc("R5", ($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
          ($urandom % 8) != 0, ($urandom % 6) != 0, ($urandom % 8) == 0,
          ($urandom % 3) != 0, rnd[0] | rnd[1], ($urandom % 40) == 0,
          32'(i * 4 + 32'h400));
    end
    cyc("R5", 0,0,0,0,0,0,0,0,0, 32'h0);
    @(negedge clk); #8;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule